// File: doc/BRIEF.md
# Linear Chirp Frequency Sweep Engine

This block produces a linear frequency ramp for a direct digital synthesizer. A frequency register starts at a programmed start frequency and advances by a signed step every clock. A phase accumulator integrates that frequency and hands the top bits of the phase to a downstream sine stage. A positive step sweeps upward and a step with its sign bit set sweeps downward. With no intervention the sweep runs indefinitely and wraps modulo 2^48. The frequency is never forced to a destination value.

Software writes bytes into shadow registers. Those writes have no effect until an update event copies the shadows into the active set. An update event comes from an external strobe or from an internal 32-bit timer that fires at a programmed interval. The timer keeps commits aligned to the system clock. If the timer is also set to reload the start frequency on every event, the output becomes a repeating sawtooth chirp. A hold input freezes the frequency. A frequency clear returns the sweep to its start point. A phase clear cuts the output phase to zero.

Top module: `chirp_sweep`

## Requirements
- R1: After reset, `freq_word` and `phase_word` are zero and `upd_event` is low.
- R2: Writes go to shadow registers. The start frequency uses bytes 0x00..0x05 and the step uses 0x08..0x0D, each with the most significant byte at the lowest address. The timer period uses 0x10..0x13, also MSB first. Control is 0x18: bit0 enables the timer, bit1 reloads the start frequency on each update event, bit2 clears the phase on each update event. A write changes no output until the next update event.
- R3: `upd_strobe` high at a clock edge commits all shadows at that edge. If the newly committed control has bit1 set, `freq_word` equals the start frequency after that edge.
- R4: When not held and not cleared, `freq_word` gains the active step at every clock, modulo 2^48.
- R5: A step with its MSB set is a negative two's-complement value, and the frequency decreases by its magnitude each clock.
- R6: While `hold` is high, `freq_word` keeps its value. An all-zero step also keeps it constant.
- R7: `freq_clr` high loads the active start frequency at the next edge. It takes priority over `hold`.
- R8: The 48-bit phase accumulator adds `freq_word` every clock, and `phase_word` is its top 14 bits. `phase_clr` high, or an update event with control bit2 set, zeroes the accumulator at that edge.
- R9: With control bit0 active and period P, `upd_event` pulses for one clock every P+1 clocks.
- R10: A new period written while the timer runs takes effect only after the interval in progress has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 8 | Byte address |
| wr_data | input | 8 | Byte data |
| upd_strobe | input | 1 | External update request |
| hold | input | 1 | Freeze the frequency |
| freq_clr | input | 1 | Return the frequency to the start value |
| phase_clr | input | 1 | Force the phase accumulator to zero |
| upd_event | output | 1 | Update event in this cycle |
| freq_word | output | 48 | Current frequency word |
| phase_word | output | 14 | Output phase, top bits of the accumulator |

## Verification
A wrong active step or start frequency shows on `freq_word` one clock after the commit edge, because the output either changes by the wrong amount or starts from the wrong point. A wrong frequency shows on `phase_word` only after enough cycles have passed for the error to reach the top 14 bits. The tests therefore use frequencies large enough that one error shows up within a few clocks. A wrong timer count appears as an event interval that differs from P+1. A period committed too early shortens the interval that was already running.

// File: rtl/chirp_sweep.sv
module chirp_sweep #(
  parameter int FW = 48,
  parameter int PW = 14,
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          upd_strobe,
  input  logic          hold,
  input  logic          freq_clr,
  input  logic          phase_clr,
  output logic          upd_event,
  output logic [FW-1:0] freq_word,
  output logic [PW-1:0] phase_word
);
  localparam int FB = FW / 8;
  localparam int TB = TW / 8;

  logic [FW-1:0] f1_sh, dlt_sh, f1_a, dlt_a, freq, ph;
  logic [TW-1:0] per_sh, cnt;
  logic [2:0]    ctl_sh, ctl_a;
  logic          fire, fclr, pclr;

  assign fire       = ctl_a[0] && (cnt == '0);
  assign upd_event  = upd_strobe | fire;
  assign fclr       = freq_clr | (upd_event & ctl_sh[1]);
  assign pclr       = phase_clr | (upd_event & ctl_sh[2]);
  assign freq_word  = freq;
  assign phase_word = ph[FW-1 -: PW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f1_sh  <= '0;
      dlt_sh <= '0;
      per_sh <= '0;
      ctl_sh <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < FB; i++) begin
        if (wr_addr == 8'(i))     f1_sh[8*(FB-1-i) +: 8]  <= wr_data;
        if (wr_addr == 8'(8 + i)) dlt_sh[8*(FB-1-i) +: 8] <= wr_data;
      end
      for (int i = 0; i < TB; i++)
        if (wr_addr == 8'(16 + i)) per_sh[8*(TB-1-i) +: 8] <= wr_data;
      if (wr_addr == 8'h18) ctl_sh <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f1_a  <= '0;
      dlt_a <= '0;
      ctl_a <= '0;
    end else if (upd_event) begin
      f1_a  <= f1_sh;
      dlt_a <= dlt_sh;
      ctl_a <= ctl_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (!ctl_a[0] || cnt == '0)  cnt <= per_sh;
    else                              cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     freq <= '0;
    else if (fclr)  freq <= upd_event ? f1_sh : f1_a;
    else if (!hold) freq <= freq + dlt_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph <= '0;
    else if (pclr)  ph <= '0;
    else            ph <= ph + freq;
  end
endmodule

module chirp_sweep_chk #(
  parameter int FW = 48,
  parameter int PW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold,
  input logic          freq_clr,
  input logic          phase_clr,
  input logic          upd_strobe,
  input logic          upd_event,
  input logic          auto_en,
  input logic [FW-1:0] freq_word,
  input logic [PW-1:0] phase_word,
  input logic [FW-1:0] f1_a,
  input logic [FW-1:0] dlt_a
);
  assert_shadow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_event |=> ($stable(dlt_a) && $stable(f1_a)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !freq_clr && !upd_event) |=> $stable(freq_word));

  assert_clr_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_clr && !upd_event) |=> (freq_word == $past(f1_a)));

  assert_phase_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> (phase_word == '0));

  assert_timer_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_event && !upd_strobe) |-> auto_en);
endmodule

bind chirp_sweep chirp_sweep_chk #(.FW(FW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .freq_clr(freq_clr),
  .phase_clr(phase_clr), .upd_strobe(upd_strobe), .upd_event(upd_event),
  .auto_en(ctl_a[0]), .freq_word(freq_word), .phase_word(phase_word),
  .f1_a(f1_a), .dlt_a(dlt_a)
);

// File: tb/test_chirp_sweep.sv
`timescale 1ns/1ps
module test_chirp_sweep;
  logic clk = 0, rst_n = 0, wr_en = 0, upd_strobe = 0, hold = 0, freq_clr = 0, phase_clr = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic upd_event;
  logic [47:0] freq_word;
  logic [13:0] phase_word;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chirp_sweep i_chirp_sweep (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr48(logic [7:0] base, logic [47:0] v);
    for (int i = 0; i < 6; i++) wr(base + 8'(i), v[8*(5-i) +: 8]);
  endtask

  task automatic wr32(logic [7:0] base, logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(base + 8'(i), v[8*(3-i) +: 8]);
  endtask

  task automatic strobe();
    upd_strobe = 1;
    @(negedge clk);
    upd_strobe = 0;
  endtask

  task automatic setup(logic [47:0] f1, logic [47:0] d, logic [7:0] ctl);
    wr48(8'h00, f1); wr48(8'h08, d); wr(8'h18, ctl); strobe();
  endtask

  task automatic wait_evt(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!upd_event && n < 200);
  endtask

  task automatic t_reset();
    chk("R1 freq", freq_word, 0);
    chk("R1 phase", phase_word, 0);
    chk("R1 event", upd_event, 0);
  endtask

  task automatic t_sweep();
    logic [47:0] f0;
    setup(48'h0000_1000_0000, 48'h100, 8'h02);
    chk("R3 start", freq_word, 48'h0000_1000_0000);
    repeat (5) @(negedge clk);
    chk("R4 ramp", freq_word, 48'h0000_1000_0500);
    f0 = freq_word;
    wr48(8'h08, 48'h7);
    chk("R2 shadow step", freq_word, f0 + 48'h600);
    strobe();
    chk("R3 recommit", freq_word, 48'h0000_1000_0000);
    repeat (4) @(negedge clk);
    chk("R4 new step", freq_word, 48'h0000_1000_001C);
  endtask

  task automatic t_down();
    logic [47:0] f;
    setup(48'h0000_1000_0000, 48'hFFFF_FFFF_FFFD, 8'h02);
    repeat (10) @(negedge clk);
    chk("R5 down", freq_word, 48'h0000_0FFF_FFE2);
    hold = 1; f = freq_word;
    repeat (5) @(negedge clk);
    chk("R6 hold", freq_word, f);
    hold = 0;
    repeat (3) @(negedge clk);
    chk("R6 resume", freq_word, f - 48'd9);
    setup(48'h0000_2000_0000, 48'h0, 8'h02);
    repeat (5) @(negedge clk);
    chk("R6 zero step", freq_word, 48'h0000_2000_0000);
  endtask

  task automatic t_clear();
    setup(48'h0000_3000_0000, 48'h100, 8'h02);
    repeat (4) @(negedge clk);
    hold = 1; freq_clr = 1;
    @(negedge clk);
    freq_clr = 0;
    chk("R7 clear over hold", freq_word, 48'h0000_3000_0000);
    repeat (2) @(negedge clk);
    chk("R7 held after clear", freq_word, 48'h0000_3000_0000);
    hold = 0;
    setup(48'hFFFF_FFFF_FFF0, 48'h20, 8'h02);
    @(negedge clk);
    chk("R4 wrap", freq_word, 48'h10);
  endtask

  task automatic t_phase();
    setup(48'h1000_0000_0000, 48'h0, 8'h02);
    phase_clr = 1;
    @(negedge clk);
    phase_clr = 0;
    chk("R8 phase clear", phase_word, 0);
    repeat (3) @(negedge clk);
    chk("R8 accumulate", phase_word, 14'd3072);
    setup(48'h1000_0000_0000, 48'h0, 8'h04);
    chk("R8 clear on event", phase_word, 0);
  endtask

  task automatic t_timer();
    int n;
    wr32(8'h10, 32'd9);
    setup(48'h0000_4000_0000, 48'h40, 8'h03);
    wait_evt(n);
    wait_evt(n);
    chk("R9 interval", n, 10);
    @(negedge clk);
    chk("R3 sawtooth restart", freq_word, 48'h0000_4000_0000);
    wait_evt(n);
    wr32(8'h10, 32'd4);
    wait_evt(n);
    chk("R10 old period kept", n, 6);
    wait_evt(n);
    chk("R10 new period", n, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_sweep();
    t_down();
    t_clear();
    t_phase();
    t_timer();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule